// File: doc/BRIEF.md
# Oversampled Serial Receiver with Ninth-Bit Address Filter

This block receives asynchronous serial frames and turns them into bytes. A frame is one start bit (low), then 8 data bits, or 9 when nine-bit mode is on, least significant bit first, then one stop bit (high). An external tick, pulsing at sixteen times the bit rate, drives bit recovery. Each bit is decided by a majority vote of three samples taken at its middle. Finished characters go into a two-entry receive queue. The head entry is always shown on the read-side outputs, and a read strobe removes it.

For multi-drop buses the block has an address filter. When the filter is on in nine-bit mode, only frames whose ninth bit is 1 are queued. Software turns the filter off once it sees its own address, and from then on every frame is queued. The block also reports a framing error for each entry and an idle indication. It raises an interrupt request while data is waiting. An overrun flag marks lost frames and stays set until the receive enable is dropped.

Top module: `uart_addr_rx`

## Requirements
- R1: Frames are received only while `port_en`=1, `sync_mode`=0 and `rx_en`=1. At any other time no frame is queued and `rx_idle` stays high.
- R2: Data bits arrive least significant bit first. The low 8 bits appear on `rd_data`. In nine-bit mode (`nine_bit`=1) the ninth received bit appears on `rd_bit9`. In eight-bit mode `rd_bit9` reads 0.
- R3: `rx_flag` is high exactly while the queue holds at least one entry. `irq` equals `rx_flag` AND `irq_en`.
- R4: The queue holds two entries in arrival order. A pulse on `rd_pop` while it is non-empty removes the oldest entry, and the next entry then appears on the outputs.
- R5: With `addr_det`=1 and `nine_bit`=1, a frame whose ninth bit is 0 is dropped without trace. Every entry queued in this mode shows `rd_bit9`=1.
- R6: After `addr_det` returns to 0, frames whose ninth bit is 0 are queued again.
- R7: A frame that completes while the queue is full sets `ovr_flag` and is lost. While `ovr_flag` is set, no frame enters the queue, even after the queue has been emptied.
- R8: `ovr_flag` is cleared only by driving `rx_en` low. Reading entries leaves it set.
- R9: Each bit is the majority of samples at ticks 7, 8 and 9 of its 16-tick period. A start bit whose vote is high is treated as a glitch, and no frame is produced.
- R10: An entry's `rd_ferr` is 1 when its stop bit voted low, and 0 otherwise.
- R11: `rx_idle` is low while a frame is being received and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversample tick, 16 per bit period |
| rxd | input | 1 | Serial input line (idle high) |
| port_en | input | 1 | Serial port enable |
| sync_mode | input | 1 | Synchronous mode select; must be 0 for reception |
| rx_en | input | 1 | Continuous receive enable; a low level clears overrun |
| nine_bit | input | 1 | Selects 9 data bits per frame |
| addr_det | input | 1 | Ninth-bit address filter enable |
| irq_en | input | 1 | Receive interrupt enable |
| rd_pop | input | 1 | Read strobe; removes the head entry |
| rd_data | output | 8 | Head entry data byte |
| rd_bit9 | output | 1 | Head entry ninth bit |
| rd_ferr | output | 1 | Head entry framing error |
| rx_flag | output | 1 | Queue not empty |
| ovr_flag | output | 1 | Sticky overrun flag |
| rx_idle | output | 1 | No frame in progress |
| irq | output | 1 | Receive interrupt request |

## Verification
The bench uses the default parameters: 16x oversampling and a two-entry queue. It holds `os_tick` high, so one bit lasts exactly 16 clocks. At that rate a full queue, a third and a fourth frame, and the recovery after the overrun clear all fit in a short run. A four-clock low pulse lands entirely before the sampling window, which exercises the start-glitch rejection. A stop bit held low leaves a tail that the receiver takes as a new start edge, so the same test also produces a second glitch rejection right after a framing error.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int RX_DW = 8;

  typedef struct packed {
    logic             ferr;
    logic             bit9;
    logic [RX_DW-1:0] data;
  } rx_entry_t;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_START = 2'd1,
    S_DATA  = 2'd2,
    S_STOP  = 2'd3
  } rx_state_t;
endpackage

// File: rtl/rx_bit_sampler.sv
module rx_bit_sampler
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      rxd,
  input  logic      enable,
  input  logic      nine,
  output logic      done,
  output rx_entry_t dout,
  output logic      idle
);
  localparam int CW  = $clog2(OSR);
  localparam int MID = OSR / 2;
  localparam int SW  = RX_DW + 1;
  localparam int BW  = $clog2(SW + 1);

  logic [1:0]    sync_q;
  rx_state_t     state;
  logic [CW-1:0] cnt;
  logic [1:0]    votes;
  logic [SW-1:0] shreg;
  logic [BW-1:0] nbit;
  logic          vote;
  logic          at_decide;
  logic          at_end;
  logic [BW-1:0] nbits_need;

  assign vote       = (votes[1] & votes[0]) | (votes[1] & sync_q[1]) | (votes[0] & sync_q[1]);
  assign at_decide  = tick && (cnt == CW'(MID + 1));
  assign at_end     = tick && (cnt == CW'(OSR - 1));
  assign nbits_need = nine ? BW'(SW) : BW'(RX_DW);

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b11;
    else     sync_q <= {sync_q[0], rxd};
  end

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst || !enable) begin
      state <= S_IDLE;
      cnt   <= '0;
      votes <= '0;
      nbit  <= '0;
      shreg <= '0;
      idle  <= 1'b1;
      dout  <= '0;
    end else begin
      if (tick && state != S_IDLE) begin
        cnt <= cnt + 1'b1;
        if (cnt == CW'(MID - 1) || cnt == CW'(MID))
          votes <= {votes[0], sync_q[1]};
      end
      case (state)
        S_IDLE: begin
          if (tick && !sync_q[1]) begin
            state <= S_START;
            cnt   <= '0;
            idle  <= 1'b0;
          end
        end
        S_START: begin
          if (at_decide && vote) begin
            state <= S_IDLE;
            idle  <= 1'b1;
          end else if (at_end) begin
            state <= S_DATA;
            nbit  <= '0;
          end
        end
        S_DATA: begin
          if (at_decide) begin
            shreg <= {vote, shreg[SW-1:1]};
            nbit  <= nbit + 1'b1;
          end
          if (at_end && nbit == nbits_need) state <= S_STOP;
        end
        S_STOP: begin
          if (at_decide) begin
            state     <= S_IDLE;
            idle      <= 1'b1;
            done      <= 1'b1;
            dout.ferr <= ~vote;
            if (nine) begin
              dout.data <= shreg[RX_DW-1:0];
              dout.bit9 <= shreg[SW-1];
            end else begin
              dout.data <= shreg[SW-1:1];
              dout.bit9 <= 1'b0;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !enable |=> idle); // R1

  AST_DONE_IS_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> idle); // R11
endmodule

// File: rtl/rx_queue.sv
module rx_queue
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      push,
  input  rx_entry_t din,
  input  logic      pop,
  output rx_entry_t dout,
  output logic      empty,
  output logic      full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);

  rx_entry_t     mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [NW-1:0] count;
  logic          do_push;
  logic          do_pop;

  assign empty   = (count == '0);
  assign full    = (count == NW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= NW'(DEPTH)); // R4

  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && !empty) |=> (count == $past(count) - 1'b1)); // R4
endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx
  import uart_rx_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             os_tick,
  input  logic             rxd,
  input  logic             port_en,
  input  logic             sync_mode,
  input  logic             rx_en,
  input  logic             nine_bit,
  input  logic             addr_det,
  input  logic             irq_en,
  input  logic             rd_pop,
  output logic [RX_DW-1:0] rd_data,
  output logic             rd_bit9,
  output logic             rd_ferr,
  output logic             rx_flag,
  output logic             ovr_flag,
  output logic             rx_idle,
  output logic             irq
);
  logic      active;
  logic      smp_done;
  rx_entry_t smp_ent;
  rx_entry_t head;
  logic      q_empty;
  logic      q_full;
  logic      accept;
  logic      push;
  logic      ovr_q;

  assign active = port_en && !sync_mode && rx_en;

  rx_bit_sampler #(.OSR(OSR)) u_smp (
    .clk    (clk),
    .rst    (rst),
    .tick   (os_tick),
    .rxd    (rxd),
    .enable (active),
    .nine   (nine_bit),
    .done   (smp_done),
    .dout   (smp_ent),
    .idle   (rx_idle)
  );

  assign accept = smp_done && !(addr_det && nine_bit && !smp_ent.bit9);
  assign push   = accept && !ovr_q && !q_full;

  always_ff @(posedge clk) begin
    if (rst || !rx_en)               ovr_q <= 1'b0;
    else if (accept && q_full)       ovr_q <= 1'b1;
  end

  rx_queue #(.DEPTH(DEPTH)) u_q (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .din   (smp_ent),
    .pop   (rd_pop),
    .dout  (head),
    .empty (q_empty),
    .full  (q_full)
  );

  assign rd_data  = head.data;
  assign rd_bit9  = head.bit9;
  assign rd_ferr  = head.ferr;
  assign rx_flag  = !q_empty;
  assign irq      = !q_empty && irq_en;
  assign ovr_flag = ovr_q;

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovr_q && rx_en) |=> ovr_q); // R8

  AST_OVR_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (ovr_q && !rd_pop) |=> $stable(rx_flag)); // R7

  AST_ADDR_ONLY: assert property (@(posedge clk) disable iff (rst)
    (addr_det && nine_bit && $past(addr_det && nine_bit) && $rose(rx_flag)) |-> rd_bit9); // R5
endmodule

// File: tb/uart_addr_rx_test.sv
module uart_addr_rx_test;
  localparam int OSR = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       os_tick = 1'b1;
  logic       rxd = 1'b1;
  logic       port_en = 1'b1;
  logic       sync_mode = 1'b0;
  logic       rx_en = 1'b1;
  logic       nine_bit = 1'b0;
  logic       addr_det = 1'b0;
  logic       irq_en = 1'b1;
  logic       rd_pop = 1'b0;
  logic [7:0] rd_data;
  logic       rd_bit9, rd_ferr, rx_flag, ovr_flag, rx_idle, irq;

  int n_run = 0;
  int n_fail = 0;
  logic idle_mid;

  always #4 clk = ~clk;

  uart_addr_rx #(.OSR(OSR), .DEPTH(2)) uut (
    .clk(clk), .rst(rst), .os_tick(os_tick), .rxd(rxd),
    .port_en(port_en), .sync_mode(sync_mode), .rx_en(rx_en),
    .nine_bit(nine_bit), .addr_det(addr_det), .irq_en(irq_en),
    .rd_pop(rd_pop), .rd_data(rd_data), .rd_bit9(rd_bit9),
    .rd_ferr(rd_ferr), .rx_flag(rx_flag), .ovr_flag(ovr_flag),
    .rx_idle(rx_idle), .irq(irq)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_frame(input logic [8:0] v, input logic nine, input logic stop_v);
    int nb;
    nb = nine ? 9 : 8;
    @(negedge clk);
    rxd = 1'b0;
    idle_cycles(OSR);
    for (int b = 0; b < nb; b++) begin
      rxd = v[b];
      idle_cycles(OSR / 2);
      if (b == 0) idle_mid = rx_idle;
      idle_cycles(OSR - OSR / 2);
    end
    rxd = stop_v;
    idle_cycles(OSR);
    rxd = 1'b1;
    idle_cycles(OSR + 4);
  endtask

  task automatic pop_one;
    @(negedge clk);
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R3", "rx_flag after reset", rx_flag, 0);
    check("R3", "irq after reset", irq, 0);
    check("R8", "ovr after reset", ovr_flag, 0);
    check("R11", "idle after reset", rx_idle, 1);
  endtask

  task automatic t_basic8;
    send_frame(9'h0A5, 1'b0, 1'b1);
    check("R11", "idle low mid-frame", idle_mid, 0);
    check("R2", "8-bit data", rd_data, 8'hA5);
    check("R2", "bit9 in 8-bit mode", rd_bit9, 0);
    check("R10", "no framing error", rd_ferr, 0);
    check("R3", "rx_flag set", rx_flag, 1);
    check("R3", "irq with enable", irq, 1);
    irq_en = 1'b0;
    @(negedge clk);
    check("R3", "irq masked", irq, 0);
    irq_en = 1'b1;
    pop_one();
    check("R3", "rx_flag clear after pop", rx_flag, 0);
    check("R3", "irq clear after pop", irq, 0);
  endtask

  task automatic t_nine;
    nine_bit = 1'b1;
    send_frame(9'h13C, 1'b1, 1'b1);
    check("R2", "9-bit data low byte", rd_data, 8'h3C);
    check("R2", "9-bit ninth bit", rd_bit9, 1);
    pop_one();
    send_frame(9'h0C1, 1'b1, 1'b1);
    check("R2", "9-bit data ninth 0", rd_data, 8'hC1);
    check("R2", "ninth bit 0", rd_bit9, 0);
    pop_one();
    nine_bit = 1'b0;
  endtask

  task automatic t_disabled;
    port_en = 1'b0;
    send_frame(9'h055, 1'b0, 1'b1);
    check("R1", "port disabled: no entry", rx_flag, 0);
    check("R1", "port disabled: idle mid-frame", idle_mid, 1);
    port_en = 1'b1;
    sync_mode = 1'b1;
    send_frame(9'h055, 1'b0, 1'b1);
    check("R1", "sync mode: no entry", rx_flag, 0);
    sync_mode = 1'b0;
    rx_en = 1'b0;
    send_frame(9'h055, 1'b0, 1'b1);
    check("R1", "rx disabled: no entry", rx_flag, 0);
    rx_en = 1'b1;
    send_frame(9'h066, 1'b0, 1'b1);
    check("R1", "re-enabled: entry", rx_flag, 1);
    check("R1", "re-enabled data", rd_data, 8'h66);
    pop_one();
  endtask

  task automatic t_order;
    send_frame(9'h011, 1'b0, 1'b1);
    send_frame(9'h022, 1'b0, 1'b1);
    check("R4", "first head", rd_data, 8'h11);
    check("R7", "two entries no overrun", ovr_flag, 0);
    pop_one();
    check("R4", "second head", rd_data, 8'h22);
    check("R4", "still non-empty", rx_flag, 1);
    pop_one();
    check("R4", "empty after two pops", rx_flag, 0);
    pop_one();
    check("R4", "pop on empty keeps empty", rx_flag, 0);
  endtask

  task automatic t_addr;
    nine_bit = 1'b1;
    addr_det = 1'b1;
    send_frame(9'h0AA, 1'b1, 1'b1);
    check("R5", "data frame dropped", rx_flag, 0);
    send_frame(9'h1C3, 1'b1, 1'b1);
    check("R5", "address frame queued", rx_flag, 1);
    check("R5", "address data", rd_data, 8'hC3);
    check("R5", "address bit9", rd_bit9, 1);
    pop_one();
    addr_det = 1'b0;
    send_frame(9'h044, 1'b1, 1'b1);
    check("R6", "data frame after filter off", rx_flag, 1);
    check("R6", "data value", rd_data, 8'h44);
    check("R6", "bit9 zero", rd_bit9, 0);
    pop_one();
    nine_bit = 1'b0;
  endtask

  task automatic t_overrun;
    send_frame(9'h001, 1'b0, 1'b1);
    send_frame(9'h002, 1'b0, 1'b1);
    check("R7", "no overrun at two", ovr_flag, 0);
    send_frame(9'h003, 1'b0, 1'b1);
    check("R7", "overrun on third", ovr_flag, 1);
    check("R7", "head kept", rd_data, 8'h01);
    send_frame(9'h004, 1'b0, 1'b1);
    pop_one();
    check("R7", "second entry kept", rd_data, 8'h02);
    pop_one();
    check("R7", "lost frames not queued", rx_flag, 0);
    check("R8", "overrun survives reads", ovr_flag, 1);
    send_frame(9'h005, 1'b0, 1'b1);
    check("R7", "blocked while overrun", rx_flag, 0);
    @(negedge clk);
    rx_en = 1'b0;
    @(negedge clk);
    rx_en = 1'b1;
    @(negedge clk);
    check("R8", "overrun cleared by rx_en", ovr_flag, 0);
    send_frame(9'h006, 1'b0, 1'b1);
    check("R8", "receive resumes", rx_flag, 1);
    check("R8", "resumed data", rd_data, 8'h06);
    pop_one();
  endtask

  task automatic t_ferr;
    send_frame(9'h05A, 1'b0, 1'b0);
    check("R10", "framing error data", rd_data, 8'h5A);
    check("R10", "framing error flag", rd_ferr, 1);
    pop_one();
    check("R9", "low stop tail not a frame", rx_flag, 0);
    send_frame(9'h0A6, 1'b0, 1'b1);
    check("R10", "clean stop after error", rd_ferr, 0);
    pop_one();
  endtask

  task automatic t_glitch;
    @(negedge clk);
    rxd = 1'b0;
    idle_cycles(4);
    rxd = 1'b1;
    idle_cycles(3 * OSR);
    check("R9", "glitch gives no entry", rx_flag, 0);
    check("R9", "idle after glitch", rx_idle, 1);
    send_frame(9'h03C, 1'b0, 1'b1);
    check("R9", "frame after glitch", rd_data, 8'h3C);
    pop_one();
  endtask

  initial begin
    idle_cycles(3);
    rst = 1'b0;
    idle_cycles(4);
    t_reset();
    t_basic8();
    t_nine();
    t_disabled();
    t_order();
    t_addr();
    t_overrun();
    t_ferr();
    t_glitch();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule